// File: doc/BRIEF.md
# Compare Flags and Branch Decision Unit

This unit does the decision half of conditional control flow. A compare request subtracts operand B from operand A, throws the difference away and keeps four condition bits in a flag register. A later branch request names one of eight conditions and gets back a taken or not-taken answer based on those stored bits.

A second branch form, the fused form, works on the two operands presented with the request itself. It compares them and decides in the same operation, and the flag register is left alone. Both forms use one 3-bit condition code, so a compiler can emit either a separate compare followed by a jump, or a single compare-and-branch. The unit does not compute branch targets.

Top module: `cmp_branch_unit`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `flags_o`, `taken_o` and `taken_valid_o` are all zero.
- R2: Bit 2 of `flags_o` is the zero flag. It is set when A equals B at the last compare. Flags take the new value on the clock edge where `cmp_valid` is sampled high.
- R3: Bit 3 of `flags_o` is the sign flag. It equals bit 31 of A minus B, taken modulo 2^32.
- R4: Bit 1 of `flags_o` is the borrow flag. It is set when A is below B as unsigned numbers.
- R5: Bit 0 of `flags_o` is the overflow flag. It is set when A minus B overflows as a two's-complement subtraction.
- R6: The flag register holds its value on every cycle where `cmp_valid` is low, whatever the other inputs do.
- R7: A branch request (`br_valid` high) gives `taken_valid_o` high on the next cycle, with the decision on `taken_o`. The condition codes are: 0 always, 1 equal (zero flag), 2 not equal, 3 signed less (sign differs from overflow), 4 signed greater-or-equal (sign equals overflow), 5 unsigned below (borrow), 6 unsigned at-or-above (no borrow), 7 never.
- R8: A flag-based branch (`br_fused` low) in the same cycle as a compare decides on the flags from before that compare.
- R9: A fused branch (`br_fused` high) decides from the current A and B. It leaves the flag register unchanged when `cmp_valid` is low.
- R10: For the same operands and condition, a fused branch and a flag-based branch after a compare give the same decision.
- R11: On a cycle after one with `br_valid` low, both `taken_valid_o` and `taken_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_valid | input | 1 | Compare request: store flags of A minus B |
| opnd_a | input | 32 | Operand A (minuend) |
| opnd_b | input | 32 | Operand B (subtrahend) |
| br_valid | input | 1 | Branch request |
| br_fused | input | 1 | 1: decide from A and B; 0: decide from stored flags |
| br_cond | input | 3 | Condition code |
| flags_o | output | 4 | Stored flags {sign, zero, borrow, overflow} |
| taken_o | output | 1 | Branch decision, valid with taken_valid_o |
| taken_valid_o | output | 1 | Decision valid, one cycle after br_valid |

## Verification
The operand pairs are chosen to hit each flag at its edge. They include equal operands, the most negative value minus one (signed overflow with no borrow), a positive value minus minus-one (overflow, sign and borrow all set), and an all-ones value minus zero (sign set with no borrow). A design that takes the borrow from the sign bit, or gets the overflow rule wrong, splits the signed conditions from the unsigned ones in a way the per-condition checks catch. A compare and a flag-based branch are issued in the same cycle: a design that forwards the new flags into that branch decides on the wrong values. Fused branches are run against the same operands as the flag-based ones. If the fused path touches the flag register or uses its own condition decode, the two forms disagree or the held flags change.

// File: rtl/cbu_pkg.sv
package cbu_pkg;

    typedef enum logic [2:0] {
        COND_ALWAYS = 3'd0,
        COND_EQ     = 3'd1,
        COND_NE     = 3'd2,
        COND_LT     = 3'd3,
        COND_GE     = 3'd4,
        COND_LTU    = 3'd5,
        COND_GEU    = 3'd6,
        COND_NEVER  = 3'd7
    } cbu_cond_e;

    typedef struct packed {
        logic sign;
        logic zero;
        logic borrow;
        logic ovf;
    } cbu_flags_t;

    typedef struct packed {
        cbu_flags_t flags;
        logic       taken;
        logic       taken_vld;
    } cbu_state_t;

endpackage

// File: rtl/cbu_flag_gen.sv
module cbu_flag_gen
    import cbu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output cbu_flags_t        flags_o
);
    localparam int MSB = DATA_W - 1;

    logic [DATA_W:0] diff_ext;

    always_comb begin
        diff_ext       = {1'b0, a_i} - {1'b0, b_i};
        flags_o.sign   = diff_ext[MSB];
        flags_o.zero   = (diff_ext[MSB:0] == '0);
        flags_o.borrow = diff_ext[DATA_W];
        flags_o.ovf    = (a_i[MSB] != b_i[MSB]) && (diff_ext[MSB] != a_i[MSB]);
    end
endmodule

// File: rtl/cbu_cond_eval.sv
module cbu_cond_eval
    import cbu_pkg::*;
(
    input  cbu_cond_e  cond_i,
    input  cbu_flags_t flags_i,
    output logic       taken_o
);
    always_comb begin
        unique case (cond_i)
            COND_ALWAYS: taken_o = 1'b1;
            COND_EQ:     taken_o = flags_i.zero;
            COND_NE:     taken_o = !flags_i.zero;
            COND_LT:     taken_o = flags_i.sign != flags_i.ovf;
            COND_GE:     taken_o = flags_i.sign == flags_i.ovf;
            COND_LTU:    taken_o = flags_i.borrow;
            COND_GEU:    taken_o = !flags_i.borrow;
            default:     taken_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/cmp_branch_unit.sv
module cmp_branch_unit
    import cbu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int COND_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmp_valid,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic              br_valid,
    input  logic              br_fused,
    input  logic [COND_W-1:0] br_cond,
    output logic [3:0]        flags_o,
    output logic              taken_o,
    output logic              taken_valid_o
);
    cbu_state_t st_d, st_q;
    cbu_flags_t live_flags;
    cbu_flags_t sel_flags;
    logic       decide;

    // The compare and the fused branch share one subtractor.
    cbu_flag_gen #(.DATA_W(DATA_W)) u_flag_gen (
        .a_i     (opnd_a),
        .b_i     (opnd_b),
        .flags_o (live_flags)
    );

    // One condition decoder serves both branch forms.
    cbu_cond_eval u_cond_eval (
        .cond_i  (cbu_cond_e'(br_cond)),
        .flags_i (sel_flags),
        .taken_o (decide)
    );

    always_comb begin
        sel_flags = br_fused ? live_flags : st_q.flags;
        st_d      = st_q;
        if (cmp_valid) begin
            st_d.flags = live_flags;
        end
        st_d.taken_vld = br_valid;
        st_d.taken     = br_valid && decide;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags_o       = st_q.flags;
    assign taken_o       = st_q.taken;
    assign taken_valid_o = st_q.taken_vld;
endmodule

// File: rtl/cbu_checker.sv
module cbu_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        cmp_valid,
    input logic [31:0] opnd_a,
    input logic [31:0] opnd_b,
    input logic        br_valid,
    input logic        br_fused,
    input logic [2:0]  br_cond,
    input logic [3:0]  flags_o,
    input logic        taken_o,
    input logic        taken_valid_o
);
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (flags_o == 4'b0) && !taken_o && !taken_valid_o);

    a_r2_zero_on_equal: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && opnd_a == opnd_b) |=> flags_o[2]);

    a_r4_borrow_unsigned: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_valid |=> flags_o[1] == ($past(opnd_a) < $past(opnd_b)));

    a_r6_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_valid |=> $stable(flags_o));

    a_r7_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        br_valid |=> taken_valid_o);

    a_r7_always_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && br_cond == 3'd0) |=> taken_o);

    a_r7_never_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && br_cond == 3'd7) |=> !taken_o);

    a_r10_fused_ge: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && br_fused && br_cond == 3'd4)
        |=> taken_o == ($signed($past(opnd_a)) >= $signed($past(opnd_b))));

    a_r11_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !br_valid |=> !taken_o && !taken_valid_o);
endmodule

bind cmp_branch_unit cbu_checker u_cbu_checker (.*);

// File: tb/cmp_branch_unit_tb.sv
module cmp_branch_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmp_valid = 1'b0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic        br_valid = 1'b0;
    logic        br_fused = 1'b0;
    logic [2:0]  br_cond = '0;
    logic [3:0]  flags_o;
    logic        taken_o;
    logic        taken_valid_o;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    cmp_branch_unit dut_i (.*);

    // {A, B, expected flags {sign, zero, borrow, overflow}}
    localparam logic [67:0] VECS [7] = '{
        {32'd5,        32'd5,        4'b0100},
        {32'd3,        32'd7,        4'b1010},
        {32'd7,        32'd3,        4'b0000},
        {32'h80000000, 32'd1,        4'b0001},
        {32'h7FFFFFFF, 32'hFFFFFFFF, 4'b1011},
        {32'hFFFFFFFF, 32'd0,        4'b1000},
        {32'h80000000, 32'h80000000, 4'b0100}
    };

    function automatic bit exp_taken(int c, logic [31:0] a, logic [31:0] b);
        case (c)
            0: return 1'b1;
            1: return a == b;
            2: return a != b;
            3: return $signed(a) < $signed(b);
            4: return $signed(a) >= $signed(b);
            5: return a < b;
            6: return a >= b;
            default: return 1'b0;
        endcase
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Drive one request for one cycle; outputs are sampled at the next negedge.
    task automatic step(bit cv, bit bv, bit fu, int c, logic [31:0] a, logic [31:0] b);
        @(negedge clk);
        cmp_valid = cv; br_valid = bv; br_fused = fu; br_cond = 3'(c);
        opnd_a = a; opnd_b = b;
        @(negedge clk);
        cmp_valid = 1'b0; br_valid = 1'b0; br_fused = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 flags", 32'(flags_o), 0);
        check("R1 taken", 32'(taken_o), 0);
        check("R1 valid", 32'(taken_valid_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", {29'b0, flags_o[0], taken_o, taken_valid_o}, 0);

        foreach (VECS[i]) begin
            logic [31:0] a = VECS[i][67:36];
            logic [31:0] b = VECS[i][35:4];
            logic [3:0]  ef = VECS[i][3:0];
            step(1, 0, 0, 0, a, b);
            check("R2 zero flag",     32'(flags_o[2]), 32'(ef[2]));
            check("R3 sign flag",     32'(flags_o[3]), 32'(ef[3]));
            check("R4 borrow flag",   32'(flags_o[1]), 32'(ef[1]));
            check("R5 overflow flag", 32'(flags_o[0]), 32'(ef[0]));
            check("R11 no branch",    32'({taken_o, taken_valid_o}), 0);
            for (int c = 0; c < 8; c++) begin
                // R7: flag-based decision, with different operands driven on the bus
                step(0, 1, 0, c, ~a, b + 32'd9);
                check("R7 valid", 32'(taken_valid_o), 1);
                check("R7 flag decision", 32'(taken_o), 32'(exp_taken(c, a, b)));
                check("R6 flags held", 32'(flags_o), 32'(ef));
                // R9/R10: fused decision agrees and leaves the flags alone
                step(0, 1, 1, c, a, b);
                check("R10 fused decision", 32'(taken_o), 32'(exp_taken(c, a, b)));
                check("R9 fused keeps flags", 32'(flags_o), 32'(ef));
            end
        end

        // R9: fused branch on operands unlike the stored compare
        step(1, 0, 0, 0, 32'd1, 32'd1);
        step(0, 1, 1, 1, 32'd2, 32'd9);
        check("R9 fused eq false", 32'(taken_o), 0);
        check("R9 flags unchanged", 32'(flags_o), 32'b0100);

        // R8: compare and flag branch together use the old flags (equal stored)
        step(1, 1, 0, 1, 32'd3, 32'd7);
        check("R8 old flags used", 32'(taken_o), 1);
        check("R8 new flags stored", 32'(flags_o), 32'b1010);
        step(0, 1, 0, 5, 32'd0, 32'd0);
        check("R8 next branch new flags", 32'(taken_o), 1);

        // R6: long idle with operands toggling
        for (int k = 0; k < 5; k++) begin
            step(0, 0, 0, k, 32'(k * 77), 32'hFFFF_0000);
            check("R6 idle hold", 32'(flags_o), 32'b1010);
            check("R11 idle outputs", 32'({taken_o, taken_valid_o}), 0);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule